// File: doc/BRIEF.md
# Transition-Minimising Bus Inversion Codec

This block sits on the transmit and receive ends of a wide parallel data bus. It limits how many wires switch from one transfer to the next. The bus is cut into equal groups of lines. For each group the encoder compares the new word with the value last placed on those wires, after any inversion. If a strict majority of the lines would toggle, it sends the complement of the word and raises that group's flag. The driven value is registered. It moves only on cycles where the input strobe is high, so idle cycles leave the wires quiet.

On the bus both data and flags are active-low. The block therefore presents the driven word and the flags twice: once in asserted (logical) form and once as active-low pin levels. The receive half accepts active-low pin levels and returns the original word. It does this by complementing each group whose flag is asserted. The receive half is combinational.

Top module: `dbi_codec`

## Requirements
- R1: While reset is held, and afterwards until the first strobed transfer, the logical driven word and all flags are zero. The pin-level word and pin-level flags are all ones.
- R2: One clock edge after an edge with `in_valid` high, each group of `bus_data` equals the captured input group when its flag is 0, or the bitwise complement of that group when its flag is 1.
- R3: A group's flag is set when more than half of its lines (9 or more of 16) differ between the new input group and the group value driven before that transfer.
- R4: A group whose transition count is 8 or fewer, including exactly 8, is sent uninverted with its flag clear.
- R5: Between two consecutive driven values, no group changes more than 8 of its 16 lines.
- R6: On an edge with `in_valid` low, `bus_data` and `bus_flag` keep their values whatever `in_data` carries.
- R7: `bus_data_n` is the bitwise complement of `bus_data`, and `bus_flag_n` is the bitwise complement of `bus_flag`, at all times.
- R8: `rx_data` equals the complement of `rx_data_n` XORed, group by group, with the asserted flag (the complement of `rx_flag_n`). Feeding the block's own pin outputs back therefore returns the input word.
- R9: Flag bit g covers data bits 16g+15 down to 16g: bit 0 covers 15:0, bit 1 covers 31:16, bit 2 covers 47:32 and bit 3 covers 63:48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Strobe: capture and encode `in_data` on this edge |
| in_data | input | 64 | Word to transmit |
| bus_data | output | 64 | Driven word, logical form |
| bus_flag | output | 4 | Inversion flags, logical form (1 = inverted) |
| bus_data_n | output | 64 | Driven word, active-low pin form |
| bus_flag_n | output | 4 | Inversion flags, active-low pin form |
| rx_data_n | input | 64 | Received word, active-low pin form |
| rx_flag_n | input | 4 | Received flags, active-low pin form |
| rx_data | output | 64 | Decoded original word |

## Verification
The encoded word and flags become visible one rising edge after the edge on which `in_valid` is sampled high. The bench therefore drives at a falling edge and reads the outputs at the following falling edge. The pin-level outputs and the decoded word are combinational, so they are read in that same half cycle. The receive side is read either as a loopback of the block's own pins or from directly driven pin levels. Idle cycles are checked at every falling edge against the last driven value.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  parameter int DBI_DATA_W = 64;
  parameter int DBI_GRP_W  = 16;
  localparam int DBI_NGRP  = DBI_DATA_W / DBI_GRP_W;
endpackage

// File: rtl/dbi_rst_sync.sv
module dbi_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/dbi_grp_enc.sv
module dbi_grp_enc #(
  parameter int W = 16
) (
  input  logic [W-1:0] cand,
  input  logic [W-1:0] prev,
  output logic         inv,
  output logic [W-1:0] drv
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  diff;
  logic [CW-1:0] cnt;

  always_comb begin
    diff = cand ^ prev;
    cnt  = '0;
    for (int i = 0; i < W; i++) cnt = cnt + CW'(diff[i]);
  end

  // strict majority: equal split stays uninverted
  assign inv = (cnt > CW'(W / 2));
  assign drv = inv ? ~cand : cand;
endmodule

// File: rtl/dbi_grp_dec.sv
module dbi_grp_dec #(
  parameter int W = 16
) (
  input  logic [W-1:0] pin_d_n,
  input  logic         pin_f_n,
  output logic [W-1:0] data
);
  logic         flag;
  logic [W-1:0] lvl;

  assign flag = ~pin_f_n;
  assign lvl  = ~pin_d_n;
  assign data = lvl ^ {W{flag}};
endmodule

// File: rtl/dbi_codec.sv
module dbi_codec #(
  parameter int DATA_W = dbi_pkg::DBI_DATA_W,
  parameter int GRP_W  = dbi_pkg::DBI_GRP_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [DATA_W-1:0]          in_data,
  output logic [DATA_W-1:0]          bus_data,
  output logic [DATA_W/GRP_W-1:0]    bus_flag,
  output logic [DATA_W-1:0]          bus_data_n,
  output logic [DATA_W/GRP_W-1:0]    bus_flag_n,
  input  logic [DATA_W-1:0]          rx_data_n,
  input  logic [DATA_W/GRP_W-1:0]    rx_flag_n,
  output logic [DATA_W-1:0]          rx_data
);
  localparam int NGRP = DATA_W / GRP_W;

  logic              rst_q_n;
  logic [DATA_W-1:0] drv_q, drv_d, drv_cand;
  logic [NGRP-1:0]   flg_q, flg_d, flg_cand;

  dbi_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    dbi_grp_enc #(.W(GRP_W)) u_enc (
      .cand (in_data[g*GRP_W +: GRP_W]),
      .prev (drv_q[g*GRP_W +: GRP_W]),
      .inv  (flg_cand[g]),
      .drv  (drv_cand[g*GRP_W +: GRP_W])
    );

    dbi_grp_dec #(.W(GRP_W)) u_dec (
      .pin_d_n (rx_data_n[g*GRP_W +: GRP_W]),
      .pin_f_n (rx_flag_n[g]),
      .data    (rx_data[g*GRP_W +: GRP_W])
    );
  end

  // next state: load only on strobe
  always_comb begin
    drv_d = drv_q;
    flg_d = flg_q;
    if (in_valid) begin
      drv_d = drv_cand;
      flg_d = flg_cand;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      drv_q <= '0;
      flg_q <= '0;
    end else begin
      drv_q <= drv_d;
      flg_q <= flg_d;
    end
  end

  assign bus_data   = drv_q;
  assign bus_flag   = flg_q;
  assign bus_data_n = ~drv_q;
  assign bus_flag_n = ~flg_q;
endmodule

// File: rtl/dbi_codec_chk.sv
module dbi_codec_chk #(
  parameter int DATA_W = 64,
  parameter int GRP_W  = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [DATA_W-1:0]       in_data,
  input logic [DATA_W-1:0]       bus_data,
  input logic [DATA_W/GRP_W-1:0] bus_flag
);
  localparam int NGRP = DATA_W / GRP_W;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(bus_data) && $stable(bus_flag))); // R6

  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    localparam int LO = g * GRP_W;

    AST_GROUP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (bus_data[LO +: GRP_W] ==
                    ($past(in_data[LO +: GRP_W]) ^ {GRP_W{bus_flag[g]}}))); // R2

    AST_INVERT_MAJORITY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ($countones(in_data[LO +: GRP_W] ^ bus_data[LO +: GRP_W]) > GRP_W/2))
      |=> bus_flag[g]); // R3

    AST_KEEP_EQUAL_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ($countones(in_data[LO +: GRP_W] ^ bus_data[LO +: GRP_W]) <= GRP_W/2))
      |=> !bus_flag[g]); // R4

    AST_TOGGLE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ($countones(bus_data[LO +: GRP_W] ^ $past(bus_data[LO +: GRP_W]))
                    <= GRP_W/2)); // R5
  end
endmodule

bind dbi_codec dbi_codec_chk #(.DATA_W(DATA_W), .GRP_W(GRP_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .in_valid (in_valid),
  .in_data  (in_data),
  .bus_data (bus_data),
  .bus_flag (bus_flag)
);

// File: tb/tb_dbi_codec.sv
module tb_dbi_codec;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_data;
  logic [63:0] bus_data, bus_data_n, rx_data_n, rx_data, man_d_n;
  logic [3:0]  bus_flag, bus_flag_n, rx_flag_n, man_f_n;
  logic        loop_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [63:0] m_prev;
  logic [3:0]  m_flag;

  always #2.5 clk = ~clk;

  assign rx_data_n = loop_sel ? bus_data_n : man_d_n;
  assign rx_flag_n = loop_sel ? bus_flag_n : man_f_n;

  dbi_codec dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .bus_data(bus_data), .bus_flag(bus_flag),
    .bus_data_n(bus_data_n), .bus_flag_n(bus_flag_n),
    .rx_data_n(rx_data_n), .rx_flag_n(rx_flag_n), .rx_data(rx_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void enc_model(input logic [63:0] x, input logic [63:0] prev,
                                    output logic [63:0] d, output logic [3:0] f);
    for (int g = 0; g < 4; g++) begin
      int c;
      c = $countones(x[g*16 +: 16] ^ prev[g*16 +: 16]);
      f[g] = (c > 8);
      d[g*16 +: 16] = f[g] ? ~x[g*16 +: 16] : x[g*16 +: 16];
    end
  endfunction

  task automatic pins_ok;
    chk(bus_data_n == ~bus_data && bus_flag_n == ~bus_flag, "R7 pin polarity", bus_data_n, ~bus_data);
  endtask

  task automatic send(input logic [63:0] x);
    logic [63:0] ed;
    logic [3:0]  ef;
    @(negedge clk);
    in_data  = x;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    enc_model(x, m_prev, ed, ef);
    chk(bus_data == ed, "R2 driven word", bus_data, ed);
    for (int g = 0; g < 4; g++) begin
      int c;
      c = $countones(x[g*16 +: 16] ^ m_prev[g*16 +: 16]);
      if (c > 8) chk(bus_flag[g] == 1'b1, "R3 flag set on majority", 64'(bus_flag), 64'(ef));
      else       chk(bus_flag[g] == 1'b0, "R4 flag clear at 8 or fewer", 64'(bus_flag), 64'(ef));
      chk(bus_data[g*16 +: 16] == (x[g*16 +: 16] ^ {16{bus_flag[g]}}), "R9 flag-to-group mapping",
          64'(bus_data[g*16 +: 16]), 64'(x[g*16 +: 16]));
      chk($countones(bus_data[g*16 +: 16] ^ m_prev[g*16 +: 16]) <= 8, "R5 toggle limit",
          64'(bus_data[g*16 +: 16]), 64'(m_prev[g*16 +: 16]));
    end
    pins_ok();
    chk(rx_data == x, "R8 loopback decode", rx_data, x);
    m_prev = ed;
    m_flag = ef;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      in_data = {$urandom, $urandom};
      @(negedge clk);
      chk(bus_data == m_prev && bus_flag == m_flag, "R6 hold when idle", bus_data, m_prev);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; loop_sel = 1'b1;
    man_d_n = '1; man_f_n = '1;
    m_prev = '0; m_flag = '0;
    repeat (4) @(negedge clk);
    chk(bus_data == 64'h0 && bus_flag == 4'h0, "R1 reset logical", bus_data, 64'h0);
    chk(bus_data_n == '1 && bus_flag_n == 4'hF, "R1 reset pins", bus_data_n, '1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(bus_data == 64'h0 && bus_flag == 4'h0, "R1 after release", bus_data, 64'h0);

    // groups: 8 changes, 9 changes, 16 changes, 0 changes
    send(64'h00FF_01FF_FFFF_0000);
    chk(bus_flag == 4'b0110, "R4 equal split uninverted / R3 majority", 64'(bus_flag), 64'h6);
    idle(3);
    send(64'hFFFF_FFFF_FFFF_FFFF);
    send(64'h0000_0000_0000_0000);
    send(64'hAAAA_5555_F0F0_0F0F);
    idle(2);

    for (int i = 0; i < 300; i++) begin
      send({$urandom, $urandom});
      if (($urandom % 4) == 0) idle(1 + ($urandom % 2));
    end

    // direct receive-side decoding
    loop_sel = 1'b0;
    for (int i = 0; i < 8; i++) begin
      logic [63:0] e;
      man_d_n = {$urandom, $urandom};
      man_f_n = 4'($urandom);
      #1;
      for (int g = 0; g < 4; g++) e[g*16 +: 16] = ~man_d_n[g*16 +: 16] ^ {16{~man_f_n[g]}};
      chk(rx_data == e, "R8 direct decode", rx_data, e);
    end
    done = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
      summary();
    end
  end
endmodule